// File: doc/BRIEF.md
# Scheduled Transfer List Sequencer

The sequencer keeps a small list of outgoing items in local storage and plays the list out when it is told to. Each item holds a payload word and a wait count, which sets how many idle cycles pass after the previous item (or after the start) before this item goes out. A plain write port loads items into the list. This port is used only while the sequencer is idle.

Playback starts on a trigger. The trigger is either a software start strobe or one user bit of the timing stream, chosen by a select input. Once running, the sequencer walks through the programmed number of entries. Each payload it emits carries a mask of destination links, taken from an enable bitmap. A one-cycle done pulse marks the end of the list. While playback runs, the sequencer refuses further triggers and list writes. It records refused triggers in a saturating counter and refused writes in a sticky error flag.

Top module: `sched_list_seq`

## Requirements
- R1: After reset, outValid, outData, outLinks, busy, done, missedCount and wrError are all zero.
- R2: A write (wrEn high) while busy is low stores wrData as the payload and wrDelay as the wait count of entry wrAddr, where wrAddr ranges from 0 to DEPTH-1.
- R3: The trigger is swStart OR ttcUser[ttcSel], sampled in every cycle at the rising clock edge. When a trigger is seen while busy is low and the play length is at least 1, busy is high from the next cycle. A ttcUser bit that ttcSel does not select does not start playback.
- R4: Entry 0 is emitted (outValid high, outData equal to its payload) 1+d0 cycles after the trigger cycle. Entry i is emitted 1+di cycles after entry i-1, where dk is the wait count of entry k. A wait count of 0 therefore gives back-to-back items.
- R5: While outValid is high, outLinks equals the linkEnable value of the preceding cycle. While outValid is low, outLinks is zero.
- R6: The play length L is min(listLen, DEPTH), latched at the trigger. Entries 0 to L-1 are played in order. done is high for exactly one cycle, which is the cycle of the last item, and busy is low in that cycle. For L=0, done pulses in the cycle after the trigger, and no item is emitted and busy stays low.
- R7: A trigger seen in a cycle where busy is high is ignored and increments missedCount. missedCount saturates at 2^MISS_W-1.
- R8: A write while busy is high leaves the list unchanged and sets wrError. wrError stays set until reset.
- R9: When a write and a trigger fall in the same idle cycle, the write takes effect, and the playback started by that trigger uses the newly written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per delay unit |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | List write strobe |
| wrAddr | input | $clog2(DEPTH) | Entry index to write |
| wrData | input | DATA_W | Payload of the entry |
| wrDelay | input | DLY_W | Wait count of the entry |
| listLen | input | $clog2(DEPTH+1) | Number of entries to play |
| linkEnable | input | NUM_LINKS | Destination link bitmap |
| ttcUser | input | USER_W | Timing-stream user bits |
| ttcSel | input | $clog2(USER_W) | Selects the user bit that triggers |
| swStart | input | 1 | Software start strobe |
| outValid | output | 1 | An item is emitted this cycle |
| outData | output | DATA_W | Payload of the emitted item |
| outLinks | output | NUM_LINKS | Links that receive the item |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle end-of-list pulse |
| missedCount | output | MISS_W | Saturating count of refused triggers |
| wrError | output | 1 | Sticky flag for a refused write |

## Verification
A list write and a trigger can arrive in the same cycle. Whether the write is kept depends on whether playback was already running in that cycle. The bench provokes this both ways. First it writes entry 0 in the same idle cycle as a software start, and it judges the result by the payload that comes out first. Then it writes entry 0 during a running playback and expects wrError to be set, with the old payload still coming out on the next replay. It also holds a trigger high across a long playback. This checks that the first cycle starts the list, that the following cycles only count as missed, and that the count saturates.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef struct packed {
    logic emit;       // current entry leaves this edge
    logic missed;     // trigger refused while running
    logic wrAccept;   // list write lands
    logic wrBlocked;  // list write refused while running
    logic busy;       // playback active
  } seq_strobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DLY_W  = 16,
  parameter int USER_W = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int SEL_W = $clog2(USER_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swStart,
  input  logic [USER_W-1:0] ttcUser,
  input  logic [SEL_W-1:0]  ttcSel,
  input  logic              wrEn,
  input  logic [LEN_W-1:0]  listLen,
  input  logic [DLY_W-1:0]  curDelay,
  output logic [AW-1:0]     rdIdx,
  output seq_strobe_t       strb,
  output logic              done
);
  logic             busyQ;
  logic [AW-1:0]    idxQ;
  logic [DLY_W-1:0] cntQ;
  logic [LEN_W-1:0] lenQ;
  logic             doneQ;
  logic             trig;
  logic             atGap;
  logic             lastItem;
  logic [LEN_W-1:0] effLen;

  assign trig     = swStart | ttcUser[ttcSel];
  assign effLen   = (listLen > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : listLen;
  assign atGap    = busyQ && (cntQ == curDelay);
  assign lastItem = (LEN_W'(idxQ) + LEN_W'(1)) == lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      cntQ  <= '0;
      lenQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (trig) begin
          if (effLen == '0) begin
            doneQ <= 1'b1;
          end else begin
            busyQ <= 1'b1;
            idxQ  <= '0;
            cntQ  <= '0;
            lenQ  <= effLen;
          end
        end
      end else if (atGap) begin
        cntQ <= '0;
        if (lastItem) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          idxQ <= idxQ + AW'(1);
        end
      end else begin
        cntQ <= cntQ + DLY_W'(1);
      end
    end
  end

  always_comb begin
    strb.emit      = atGap;
    strb.missed    = busyQ & trig;
    strb.wrAccept  = wrEn & ~busyQ;
    strb.wrBlocked = wrEn & busyQ;
    strb.busy      = busyQ;
  end

  assign rdIdx = idxQ;
  assign done  = doneQ;

  // R6: the end pulse coincides with leaving the running state
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ);
  // R6: the playing entry always lies inside the latched length
  a_r6_idx_in_len: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (LEN_W'(idxQ) < lenQ));
  // R4: the wait counter never passes the entry's programmed delay
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cntQ <= curDelay));
endmodule

// File: rtl/sched_dpath.sv
module sched_dpath
  import sched_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 16,
  parameter int DLY_W     = 16,
  parameter int NUM_LINKS = 8,
  parameter int MISS_W    = 8,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          strb,
  input  logic [AW-1:0]        rdIdx,
  input  logic [AW-1:0]        wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DLY_W-1:0]     wrDelay,
  input  logic [NUM_LINKS-1:0] linkEnable,
  output logic [DLY_W-1:0]     curDelay,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic [NUM_LINKS-1:0] outLinks,
  output logic [MISS_W-1:0]    missedCount,
  output logic                 wrError
);
  logic [DATA_W-1:0] payMem [DEPTH];
  logic [DLY_W-1:0]  dlyMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrAccept) begin
      payMem[wrAddr] <= wrData;
      dlyMem[wrAddr] <= wrDelay;
    end
  end

  assign curDelay = dlyMem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      outLinks    <= '0;
      missedCount <= '0;
      wrError     <= 1'b0;
    end else begin
      outValid <= strb.emit;
      outData  <= strb.emit ? payMem[rdIdx] : '0;
      outLinks <= strb.emit ? linkEnable : '0;
      if (strb.missed && (missedCount != '1)) missedCount <= missedCount + MISS_W'(1);
      if (strb.wrBlocked) wrError <= 1'b1;
    end
  end

  // R5: no destination link is flagged without an item
  a_r5_links_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outLinks != '0) |-> outValid);
  // R8: the error flag never clears once set
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrError) |-> wrError);
  // R8: the error flag only rises after a refused write
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrError) |-> $past(strb.wrBlocked));
  // R7: a refused trigger below saturation advances the count by one
  a_r7_miss_step: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.missed) && ($past(missedCount) != '1)) |->
      (missedCount == $past(missedCount) + MISS_W'(1)));
endmodule

// File: rtl/sched_list_seq.sv
module sched_list_seq
  import sched_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 16,
  parameter int DLY_W     = 16,
  parameter int NUM_LINKS = 8,
  parameter int USER_W    = 4,
  parameter int MISS_W    = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(DEPTH + 1),
  localparam int SEL_W    = $clog2(USER_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DLY_W-1:0]     wrDelay,
  input  logic [LEN_W-1:0]     listLen,
  input  logic [NUM_LINKS-1:0] linkEnable,
  input  logic [USER_W-1:0]    ttcUser,
  input  logic [SEL_W-1:0]     ttcSel,
  input  logic                 swStart,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic [NUM_LINKS-1:0] outLinks,
  output logic                 busy,
  output logic                 done,
  output logic [MISS_W-1:0]    missedCount,
  output logic                 wrError
);
  seq_strobe_t      strb;
  logic [AW-1:0]    rdIdx;
  logic [DLY_W-1:0] curDelay;

  sched_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W), .USER_W(USER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .swStart(swStart), .ttcUser(ttcUser), .ttcSel(ttcSel),
    .wrEn(wrEn), .listLen(listLen), .curDelay(curDelay), .rdIdx(rdIdx),
    .strb(strb), .done(done)
  );

  sched_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DLY_W(DLY_W),
                .NUM_LINKS(NUM_LINKS), .MISS_W(MISS_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(rdIdx), .wrAddr(wrAddr),
    .wrData(wrData), .wrDelay(wrDelay), .linkEnable(linkEnable),
    .curDelay(curDelay), .outValid(outValid), .outData(outData),
    .outLinks(outLinks), .missedCount(missedCount), .wrError(wrError)
  );

  assign busy = strb.busy;
endmodule

// File: tb/sched_list_seq_test.sv
module sched_list_seq_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int LINKS = 8;
  localparam int UW    = 4;
  localparam int MW    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [15:0] wrDelay = '0;
  logic [5:0] listLen = '0;
  logic [LINKS-1:0] linkEnable = '0;
  logic [UW-1:0] ttcUser = '0;
  logic [1:0] ttcSel = '0;
  logic swStart = 1'b0;
  logic outValid, busy, done, wrError;
  logic [DW-1:0] outData;
  logic [LINKS-1:0] outLinks;
  logic [MW-1:0] missedCount;

  int errs = 0;
  int checks = 0;
  logic [15:0] mDat [DEPTH];
  logic [15:0] mDly [DEPTH];

  sched_list_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrDelay(wrDelay), .listLen(listLen), .linkEnable(linkEnable),
    .ttcUser(ttcUser), .ttcSel(ttcSel), .swStart(swStart),
    .outValid(outValid), .outData(outData), .outLinks(outLinks), .busy(busy),
    .done(done), .missedCount(missedCount), .wrError(wrError)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wrEntry(input int a, input int d, input int w);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = 16'(d); wrDelay = 16'(w);
    tick;
    wrEn = 1'b0;
    mDat[a] = 16'(d); mDly[a] = 16'(w);
  endtask

  // kind 0: software strobe, kind 1: user bit sel
  task automatic play(input int len, input int kind, input int sel);
    int eff, ni, nextT;
    eff = (len > DEPTH) ? DEPTH : len;
    listLen = 6'(len);
    if (kind == 0) swStart = 1'b1;
    else begin ttcSel = 2'(sel); ttcUser = UW'(1 << sel); end
    tick;
    swStart = 1'b0; ttcUser = '0;
    if (eff == 0) begin
      chk(done == 1'b1 && busy == 1'b0 && outValid == 1'b0, "R6 empty list done", done, 1);
      tick;
      chk(done == 1'b0 && outValid == 1'b0, "R6 empty list pulse width", done, 0);
      return;
    end
    chk(busy == 1'b1, "R3 busy after trigger", busy, 1);
    ni = 0;
    nextT = 1 + int'(mDly[0]);
    for (int t = 1; ni < eff; t++) begin
      tick;
      if (t == nextT) begin
        chk(outValid == 1'b1, "R4 item valid timing", outValid, 1);
        chk(outData == mDat[ni], "R4 item payload", outData, mDat[ni]);
        chk(outLinks == linkEnable, "R5 item link mask", outLinks, linkEnable);
        chk(done == (ni == eff - 1), "R6 done on last item", done, ni == eff - 1);
        chk(busy == (ni != eff - 1), "R6 busy drops on last item", busy, ni != eff - 1);
        ni++;
        if (ni < eff) nextT = t + 1 + int'(mDly[ni]);
      end else begin
        chk(outValid == 1'b0 && outLinks == '0 && done == 1'b0,
            "R4 quiet between items", {outValid, done, outLinks}, 0);
      end
    end
    tick;
    chk(outValid == 1'b0 && done == 1'b0 && busy == 1'b0, "R6 idle after list",
        {outValid, done, busy}, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) tick;
    chk(outValid == 0 && outData == 0 && outLinks == 0 && busy == 0 && done == 0 &&
        missedCount == 0 && wrError == 0, "R1 reset state", {outValid, busy, done}, 0);
    rstN = 1'b1;
    tick;
    // R2: fill the whole list with computed payloads and small delays
    for (int i = 0; i < DEPTH; i++) wrEntry(i, (i * 16'h1357) ^ 16'hA5C3, i % 4);
    chk(busy == 1'b0 && wrError == 1'b0, "R2 idle writes accepted", wrError, 0);
    // R4 R5 R6: sweep lengths and link masks
    for (int k = 0; k < 7; k++) begin
      int lens [7] = '{1, 2, 3, 5, 17, 32, 40};
      linkEnable = LINKS'(8'h01 << (k % LINKS)) | LINKS'(k * 37);
      play(lens[k], 0, 0);
    end
    play(0, 0, 0);
    // R3: each user bit selected in turn
    for (int s = 0; s < UW; s++) begin
      linkEnable = LINKS'(8'hF0 >> s);
      play(3, 1, s);
    end
    // R3: unselected user bits do not start
    ttcSel = 2'd2; ttcUser = 4'b1011; listLen = 6'd4;
    tick;
    ttcUser = '0;
    chk(busy == 1'b0, "R3 unselected bit ignored", busy, 0);
    tick;
    chk(busy == 1'b0 && outValid == 1'b0, "R3 no playback from other bits", outValid, 0);
    // R4: zero delays back to back
    for (int i = 0; i < 6; i++) wrEntry(i, 16'h0F00 + i, 0);
    play(6, 0, 0);
    // R9: write entry 0 in the same idle cycle as the trigger
    listLen = 6'd2;
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 16'hBEEF; wrDelay = 16'd1;
    swStart = 1'b1;
    tick;
    wrEn = 1'b0; swStart = 1'b0;
    mDat[0] = 16'hBEEF; mDly[0] = 16'd1;
    chk(busy == 1'b1 && wrError == 1'b0, "R9 write kept with trigger", wrError, 0);
    tick; tick;
    chk(outValid == 1'b1 && outData == 16'hBEEF, "R9 new payload played", outData, 16'hBEEF);
    tick;
    chk(done == 1'b1 && outData == mDat[1], "R9 second item", outData, mDat[1]);
    tick;
    // R8: write during playback is refused; R7: triggers counted
    wrEntry(0, 16'h1111, 40);
    listLen = 6'd1;
    swStart = 1'b1;
    tick;
    swStart = 1'b0;
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 16'h2222; wrDelay = 16'd0;
    tick;
    wrEn = 1'b0;
    chk(wrError == 1'b1, "R8 error set on busy write", wrError, 1);
    for (int i = 0; i < 3; i++) begin swStart = 1'b1; tick; swStart = 1'b0; tick; end
    chk(missedCount == 3, "R7 refused triggers counted", missedCount, 3);
    while (busy) tick;
    chk(outData == 16'h1111, "R8 list unchanged after busy write", outData, 16'h1111);
    // R8: list unchanged seen again on replay, flag still set
    wrEntry(1, 16'h3333, 0);
    mDly[0] = 16'd40;
    play(1, 0, 0);
    chk(wrError == 1'b1, "R8 error sticky", wrError, 1);
    // R7: hold trigger high through a long playback, count saturates
    wrEntry(0, 16'h4444, 300);
    listLen = 6'd1;
    ttcSel = 2'd1; ttcUser = 4'b0010;
    tick;
    for (int i = 0; i < 295; i++) tick;
    ttcUser = '0;
    chk(missedCount == 8'hFF, "R7 count saturates", missedCount, 8'hFF);
    while (busy) tick;
    chk(outValid == 1'b1 && outData == 16'h4444, "R7 held trigger played once", outData, 16'h4444);
    tick;
    chk(busy == 1'b0 && missedCount == 8'hFF, "R7 no restart, count held", missedCount, 8'hFF);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule